// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. Software sets it up through a small register interface. The frame shape is chosen at run time by one mode byte: 5 to 8 data bits, optional even or odd parity, and 1, 1.5 or 2 stop bits. The same byte selects a bit time of 1, 16 or 64 periods of a shared baud tick. A separate command byte holds the transmit enable, the receive enable, a line-break request and a one-shot error clear.

The host writes bytes into a single-entry transmit holding register. It reads received characters from a single-entry receive buffer. A status byte reports the ready flags and three sticky error flags. Transmission waits for the clear-to-send input.

The receiver has three protections. It synchronises the line and re-checks the start bit at half a bit time, which rejects short glitches. After a framing error it will not start a new character until the line has returned to mark.

Top module: `serial_xcvr`

## Requirements
- R1: Register map: address 0 is the data register (a write loads the transmit holding register, a read returns the receive buffer). Address 1 writes the command byte and reads status. Address 2 writes the mode byte. Mode byte layout: [1:0] tick divide (01=1, 10=16, 11=64; 00 acts as 1), [3:2] data bits (00=5, 01=6, 10=7, 11=8), [4] parity enable, [5] parity sense (1=even, 0=odd), [7:6] stop bits (01=1, 10=1.5, 11=2; 00 acts as 1). Command byte layout: [0] transmit enable, [1] receive enable, [2] break, [3] error clear. Reset mode is 0x4E; the reset command is all zero.
- R2: A transmitted frame is one start bit (low), the data bits LSB first, the parity bit if enabled, then the stop time (high). Each bit lasts F ticks. The stop time is F ticks for 1 stop bit, F+(F+1)/2 ticks for 1.5 (2 ticks when F=1), and 2F ticks for 2. A byte that is already waiting starts directly after the stop time. The line idles high.
- R3: A frame starts only on a tick where cts_i is high and transmit enable is set. Until then the byte waits in the holding register and the line stays high.
- R4: Status layout: [0] transmit ready (holding register empty), [1] receive ready, [2] transmit empty (holding register empty and no frame in progress), [3] parity error, [4] overrun, [5] framing error, [7:6] zero. A data write clears bit 0 until the byte enters the shifter. Reset status is 0x05 and the line is high.
- R5: While the break bit is set, txd_o is held low, including in the middle of a frame.
- R6: In divide-by-16 and divide-by-64, the receiver re-checks the start bit F/2 ticks after it first sees low. It then samples every F ticks. In divide-by-1 it samples on each tick after the one that saw the start.
- R7: A low pulse that is back high by the half-bit re-check does not start a character.
- R8: A received character sets receive ready. It is read right-aligned, with the bits above the character length read as zero. Reading address 0 clears receive ready.
- R9: A received parity bit that does not match the programmed sense sets the parity error flag.
- R10: A stop bit sampled low sets the framing error flag. The receiver then waits for the line to go high before it looks for a new start bit.
- R11: A character that completes while receive ready is still set replaces the buffer and sets the overrun flag.
- R12: Error flags are sticky. A command write with bit 3 set clears all three flags; a new error in the same cycle wins.
- R13: With receive enable clear, line activity leaves receive ready and the receive buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Baud tick enable, one clock wide |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (receive buffer or status) |
| cts_i | input | 1 | Clear to send, high allows transmission |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |

## Verification
The transmitter is driven with three frame shapes:
- 8 bits, no parity, 1 stop bit at divide-by-16;
- 7 bits, even parity, 2 stop bits at divide-by-1;
- 5 bits, odd parity, 1.5 stop bits, sent back to back, so that the length of the stop time shows up as the start time of the second frame.

Each tick sample is compared with a bit sequence the bench builds itself, which separates wrong bit order, wrong parity and wrong stop length. The gating by clear-to-send, by the transmit enable and by break is checked by watching the line while a byte is held.

The receiver is fed frames at all three divide factors, with short lengths whose upper bits are set, flipped parity, a stop bit held low for several bit times, two characters with no read between them, and a glitch shorter than half a bit. Together these tell apart the sampling points, the masking, each error flag and the re-arm after a break.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  parameter int DATA_W = 8;
  parameter int TICK_W = 8;
  parameter int CNT_W  = 4;

  typedef struct packed {
    logic [1:0] stop;
    logic       even;
    logic       par_en;
    logic [1:0] len;
    logic [1:0] fac;
  } mode_t;

  function automatic logic [TICK_W-1:0] bit_ticks(input logic [1:0] fac);
    case (fac)
      2'b10:   return TICK_W'(16);
      2'b11:   return TICK_W'(64);
      default: return TICK_W'(1);
    endcase
  endfunction

  function automatic logic [TICK_W-1:0] stop_ticks(input mode_t m);
    logic [TICK_W-1:0] f;
    f = bit_ticks(m.fac);
    case (m.stop)
      2'b10:   return f + ((f + TICK_W'(1)) >> 1);
      2'b11:   return f << 1;
      default: return f;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] n_bits(input logic [1:0] len);
    return CNT_W'(5) + CNT_W'(len);
  endfunction

  function automatic logic [DATA_W-1:0] len_mask(input logic [1:0] len);
    logic [DATA_W:0] t;
    t = ({{DATA_W{1'b0}}, 1'b1} << n_bits(len)) - 1'b1;
    return t[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/xcvr_tx.sv
module xcvr_tx
  import xcvr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  mode_t             mode_i,
  input  logic              en_i,
  input  logic              cts_i,
  input  logic              brk_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] ldata_i,
  output logic              txd_o,
  output logic              hold_full_o,
  output logic              busy_o
);
  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_st_e;

  tx_st_e             st_q;
  logic [DATA_W-1:0]  hold_q, shf_q;
  logic               hold_full_q, line_q, par_q;
  logic [CNT_W-1:0]   idx_q;
  logic [TICK_W-1:0]  cnt_q;
  logic [TICK_W-1:0]  f_ticks;
  logic               start_ok, hold_par;

  assign f_ticks  = bit_ticks(mode_i.fac);
  assign start_ok = hold_full_q & en_i & cts_i;
  assign hold_par = (^(hold_q & len_mask(mode_i.len))) ^ ~mode_i.even;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= TX_IDLE;
      hold_q      <= '0;
      shf_q       <= '0;
      hold_full_q <= 1'b0;
      line_q      <= 1'b1;
      par_q       <= 1'b0;
      idx_q       <= '0;
      cnt_q       <= '0;
    end else begin
      if (tick_i) begin
        if (st_q == TX_IDLE) begin
          if (start_ok) begin
            shf_q       <= hold_q;
            par_q       <= hold_par;
            hold_full_q <= 1'b0;
            line_q      <= 1'b0;
            cnt_q       <= f_ticks - TICK_W'(1);
            st_q        <= TX_START;
          end
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - TICK_W'(1);
        end else begin
          cnt_q <= f_ticks - TICK_W'(1);
          case (st_q)
            TX_START: begin
              line_q <= shf_q[0];
              shf_q  <= shf_q >> 1;
              idx_q  <= CNT_W'(1);
              st_q   <= TX_DATA;
            end
            TX_DATA: begin
              if (idx_q == n_bits(mode_i.len)) begin
                if (mode_i.par_en) begin
                  line_q <= par_q;
                  st_q   <= TX_PAR;
                end else begin
                  line_q <= 1'b1;
                  cnt_q  <= stop_ticks(mode_i) - TICK_W'(1);
                  st_q   <= TX_STOP;
                end
              end else begin
                line_q <= shf_q[0];
                shf_q  <= shf_q >> 1;
                idx_q  <= idx_q + CNT_W'(1);
              end
            end
            TX_PAR: begin
              line_q <= 1'b1;
              cnt_q  <= stop_ticks(mode_i) - TICK_W'(1);
              st_q   <= TX_STOP;
            end
            TX_STOP: begin
              if (start_ok) begin
                shf_q       <= hold_q;
                par_q       <= hold_par;
                hold_full_q <= 1'b0;
                line_q      <= 1'b0;
                st_q        <= TX_START;
              end else begin
                st_q <= TX_IDLE;
              end
            end
            default: st_q <= TX_IDLE;
          endcase
        end
      end
      if (load_i) begin
        hold_q      <= ldata_i;
        hold_full_q <= 1'b1;
      end
    end
  end

  assign txd_o       = line_q & ~brk_i;
  assign hold_full_o = hold_full_q;
  assign busy_o      = (st_q != TX_IDLE);

  assert_cts_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TX_IDLE && !(cts_i && en_i)) |=> (st_q == TX_IDLE));

  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$past(busy_o)) |-> !txd_o);

  assert_break_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |-> !txd_o);
endmodule

// File: rtl/xcvr_rx.sv
module xcvr_rx
  import xcvr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        fac_i,
  input  logic [1:0]        len_i,
  input  logic              par_en_i,
  input  logic              even_i,
  input  logic              en_i,
  input  logic              rxd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o
);
  localparam int IDX_W = $clog2(DATA_W);

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAIT} rx_st_e;

  rx_st_e            st_q;
  logic [1:0]        sync_q;
  logic              rx_s;
  logic [DATA_W-1:0] data_q;
  logic              acc_q, perr_q, ferr_q, done_q;
  logic [CNT_W-1:0]  idx_q;
  logic [TICK_W-1:0] cnt_q, f_ticks, half;

  assign rx_s    = sync_q[1];
  assign f_ticks = bit_ticks(fac_i);
  assign half    = f_ticks >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      data_q <= '0;
      acc_q  <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        st_q <= RX_IDLE;
      end else if (tick_i) begin
        if (st_q == RX_IDLE) begin
          if (!rx_s) begin
            data_q <= '0;
            acc_q  <= 1'b0;
            idx_q  <= '0;
            perr_q <= 1'b0;
            ferr_q <= 1'b0;
            if (f_ticks == TICK_W'(1)) begin
              cnt_q <= '0;
              st_q  <= RX_DATA;
            end else begin
              cnt_q <= half - TICK_W'(1);
              st_q  <= RX_START;
            end
          end
        end else if (st_q == RX_WAIT) begin
          if (rx_s) st_q <= RX_IDLE;
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - TICK_W'(1);
        end else begin
          cnt_q <= f_ticks - TICK_W'(1);
          case (st_q)
            RX_START: st_q <= rx_s ? RX_IDLE : RX_DATA;
            RX_DATA: begin
              data_q[idx_q[IDX_W-1:0]] <= rx_s;
              acc_q <= acc_q ^ rx_s;
              idx_q <= idx_q + CNT_W'(1);
              if (idx_q == n_bits(len_i) - CNT_W'(1))
                st_q <= par_en_i ? RX_PAR : RX_STOP;
            end
            RX_PAR: begin
              perr_q <= (rx_s != (acc_q ^ ~even_i));
              st_q   <= RX_STOP;
            end
            RX_STOP: begin
              done_q <= 1'b1;
              ferr_q <= ~rx_s;
              st_q   <= rx_s ? RX_IDLE : RX_WAIT;
            end
            default: st_q <= RX_IDLE;
          endcase
        end
      end
    end
  end

  assign done_o = done_q;
  assign data_o = data_q;
  assign perr_o = perr_q;
  assign ferr_o = ferr_q;

  assert_rearm_wait_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && ferr_q) |-> (st_q == RX_WAIT));

  assert_glitch_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RX_START && tick_i && cnt_q == '0 && rx_s && en_i) |=> (st_q == RX_IDLE));
endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr
  import xcvr_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              cts_i,
  input  logic              rxd_i,
  output logic              txd_o
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(2);
  localparam logic [7:0]        MODE_RST = 8'h4E;

  mode_t             mode_q;
  logic              tx_en_q, rx_en_q, brk_q;
  logic [DATA_W-1:0] rx_buf_q;
  logic              rx_rdy_q, perr_q, ferr_q, oerr_q;
  logic              wr_data, wr_cmd, wr_mode, rd_data;
  logic              hold_full, tx_busy;
  logic              rx_done, rx_perr, rx_ferr;
  logic [DATA_W-1:0] rx_data;
  logic [7:0]        status;

  assign wr_data = wr_i && addr_i == A_DATA;
  assign wr_cmd  = wr_i && addr_i == A_CMD;
  assign wr_mode = wr_i && addr_i == A_MODE;
  assign rd_data = rd_i && addr_i == A_DATA;

  xcvr_tx u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .mode_i     (mode_q),
    .en_i       (tx_en_q),
    .cts_i      (cts_i),
    .brk_i      (brk_q),
    .load_i     (wr_data),
    .ldata_i    (wdata_i),
    .txd_o      (txd_o),
    .hold_full_o(hold_full),
    .busy_o     (tx_busy)
  );

  xcvr_rx u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .fac_i   (mode_q.fac),
    .len_i   (mode_q.len),
    .par_en_i(mode_q.par_en),
    .even_i  (mode_q.even),
    .en_i    (rx_en_q),
    .rxd_i   (rxd_i),
    .done_o  (rx_done),
    .data_o  (rx_data),
    .perr_o  (rx_perr),
    .ferr_o  (rx_ferr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= mode_t'(MODE_RST);
      tx_en_q  <= 1'b0;
      rx_en_q  <= 1'b0;
      brk_q    <= 1'b0;
      rx_buf_q <= '0;
      rx_rdy_q <= 1'b0;
      perr_q   <= 1'b0;
      ferr_q   <= 1'b0;
      oerr_q   <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= mode_t'(wdata_i[7:0]);
      if (wr_cmd) begin
        tx_en_q <= wdata_i[0];
        rx_en_q <= wdata_i[1];
        brk_q   <= wdata_i[2];
        if (wdata_i[3]) begin
          perr_q <= 1'b0;
          ferr_q <= 1'b0;
          oerr_q <= 1'b0;
        end
      end
      if (rd_data) rx_rdy_q <= 1'b0;
      // new character wins over a same-cycle read or clear
      if (rx_done) begin
        rx_buf_q <= rx_data;
        rx_rdy_q <= 1'b1;
        if (rx_rdy_q && !rd_data) oerr_q <= 1'b1;
        if (rx_perr) perr_q <= 1'b1;
        if (rx_ferr) ferr_q <= 1'b1;
      end
    end
  end

  assign status  = {2'b00, ferr_q, oerr_q, perr_q, ~hold_full & ~tx_busy, rx_rdy_q, ~hold_full};
  assign rdata_o = (addr_i == A_DATA) ? rx_buf_q : status;

  assert_txrdy_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> !status[0]);

  assert_rxrdy_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && !rx_done) |=> !rx_rdy_q);

  assert_err_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && wdata_i[3] && !rx_done) |=> (!perr_q && !ferr_q && !oerr_q));

  assert_overrun_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oerr_q) |-> $past(rx_rdy_q));
endmodule

// File: tb/serial_xcvr_tb.sv
module serial_xcvr_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       tick_seen = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = 2'd1;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       cts = 1'b1, rxd = 1'b1;
  logic       txd;
  int         n_chk = 0, n_err = 0, ph = 0;
  int         exp_q[$];

  serial_xcvr u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .cts_i(cts),
    .rxd_i(rxd), .txd_o(txd)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    ph   = ph + 1;
    tick = (ph % 4 == 0);
  end
  always @(posedge clk) tick_seen <= tick;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick_wait(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!tick_seen);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = 2'd1;
  endtask

  task automatic get_status(output logic [7:0] s);
    addr = 2'd1;
    #1 s = rdata;
  endtask

  task automatic rd_data(output logic [7:0] d);
    @(negedge clk);
    addr = 2'd0; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0; addr = 2'd1;
  endtask

  function automatic int fac_of(input logic [7:0] m);
    case (m[1:0]) 2'b10: return 16; 2'b11: return 64; default: return 1; endcase
  endfunction

  function automatic logic par_of(input logic [7:0] b, input logic [7:0] m);
    logic [7:0] mask;
    mask = 8'((9'd1 << (5 + m[3:2])) - 9'd1);
    return (^(b & mask)) ^ ~m[5];
  endfunction

  // expected line level per tick for one transmitted frame
  task automatic add_frame(input logic [7:0] b, input logic [7:0] m);
    int f, nb, sl;
    f  = fac_of(m);
    nb = 5 + m[3:2];
    case (m[7:6]) 2'b10: sl = f + (f + 1) / 2; 2'b11: sl = 2 * f; default: sl = f; endcase
    for (int i = 0; i < f; i++) exp_q.push_back(0);
    for (int j = 0; j < nb; j++) for (int i = 0; i < f; i++) exp_q.push_back(int'(b[j]));
    if (m[4]) for (int i = 0; i < f; i++) exp_q.push_back(int'(par_of(b, m)));
    for (int i = 0; i < sl; i++) exp_q.push_back(1);
  endtask

  task automatic check_tx(input string req);
    int bad, waited;
    bad = 0; waited = 0;
    do begin tick_wait(1); waited++; end while (txd !== 1'b0 && waited < 3000);
    for (int i = 0; i < exp_q.size(); i++) begin
      if (i > 0) tick_wait(1);
      if (txd !== exp_q[i][0]) bad++;
    end
    chk(req, bad, 0);
    exp_q.delete();
  endtask

  task automatic send_rx(input logic [7:0] b, input logic [7:0] m, input logic flip, input int stop_low);
    int f;
    f = fac_of(m);
    tick_wait(1);
    rxd = 1'b0; tick_wait(f);
    for (int j = 0; j < 5 + m[3:2]; j++) begin rxd = b[j]; tick_wait(f); end
    if (m[4]) begin rxd = par_of(b, m) ^ flip; tick_wait(f); end
    if (stop_low > 0) begin rxd = 1'b0; tick_wait(stop_low); end
    rxd = 1'b1; tick_wait(2 * f + 2);
  endtask

  initial begin
    #2_000_000;
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    get_status(s);
    chk("R4 reset status", s, 8'h05);
    chk("R4 reset line high", txd, 1);

    wr_reg(2'd1, 8'h03);
    add_frame(8'hA5, 8'h4E);
    fork
      check_tx("R2 8N1 x16 frame");
      begin
        wr_reg(2'd0, 8'hA5);
        get_status(s);
        chk("R4 tx ready drops on write", s[0], 0);
      end
    join
    tick_wait(2);
    get_status(s);
    chk("R4 tx ready and empty after frame", s & 8'h05, 8'h05);

    wr_reg(2'd2, 8'hF9);
    add_frame(8'h35, 8'hF9);
    fork
      check_tx("R1 7 bits even parity 2 stop x1");
      wr_reg(2'd0, 8'h35);
    join

    wr_reg(2'd2, 8'h92);
    add_frame(8'h1B, 8'h92);
    add_frame(8'h0C, 8'h92);
    fork
      check_tx("R2 1.5 stop odd parity back to back");
      begin wr_reg(2'd0, 8'h1B); tick_wait(3); wr_reg(2'd0, 8'h0C); end
    join
    tick_wait(4);

    wr_reg(2'd2, 8'h4E);
    cts = 1'b0;
    wr_reg(2'd0, 8'h55);
    bad = 0;
    for (int i = 0; i < 40; i++) begin tick_wait(1); if (txd !== 1'b1) bad++; end
    chk("R3 line idle while cts low", bad, 0);
    get_status(s);
    chk("R3 byte held while cts low", s[0], 0);
    add_frame(8'h55, 8'h4E);
    fork
      check_tx("R3 frame after cts rises");
      cts = 1'b1;
    join
    tick_wait(4);

    wr_reg(2'd1, 8'h02);
    wr_reg(2'd0, 8'h66);
    bad = 0;
    for (int i = 0; i < 40; i++) begin tick_wait(1); if (txd !== 1'b1) bad++; end
    chk("R3 line idle while tx disabled", bad, 0);
    add_frame(8'h66, 8'h4E);
    fork
      check_tx("R3 frame after tx enable");
      wr_reg(2'd1, 8'h03);
    join
    tick_wait(4);

    wr_reg(2'd1, 8'h07);
    tick_wait(2);
    chk("R5 break holds line low", txd, 0);
    wr_reg(2'd1, 8'h03);
    tick_wait(1);
    chk("R5 line high after break", txd, 1);
    wr_reg(2'd0, 8'hFF);
    tick_wait(30);
    wr_reg(2'd1, 8'h07);
    bad = 0;
    for (int i = 0; i < 10; i++) begin tick_wait(1); if (txd !== 1'b0) bad++; end
    chk("R5 break overrides frame", bad, 0);
    wr_reg(2'd1, 8'h03);
    tick_wait(200);

    send_rx(8'hC3, 8'h4E, 1'b0, 0);
    get_status(s);
    chk("R8 rx ready set", s[1], 1);
    rd_data(d);
    chk("R6 x16 data", d, 8'hC3);
    get_status(s);
    chk("R8 rx ready cleared by read", s[1], 0);

    wr_reg(2'd2, 8'h72);
    send_rx(8'hFF, 8'h72, 1'b0, 0);
    rd_data(d);
    chk("R8 5-bit right aligned", d, 8'h1F);
    get_status(s);
    chk("R9 no parity error on good char", s[3], 0);

    send_rx(8'h0A, 8'h72, 1'b1, 0);
    get_status(s);
    chk("R9 parity error flagged", s[3], 1);
    rd_data(d);
    send_rx(8'h05, 8'h72, 1'b0, 0);
    get_status(s);
    chk("R12 parity flag sticky", s[3], 1);
    wr_reg(2'd1, 8'h0B);
    get_status(s);
    chk("R12 error clear", s & 8'h38, 0);
    rd_data(d);

    wr_reg(2'd2, 8'h4E);
    send_rx(8'h3C, 8'h4E, 1'b0, 64);
    get_status(s);
    chk("R10 framing error flagged", s[5], 1);
    rd_data(d);
    chk("R10 data with framing error", d, 8'h3C);
    tick_wait(120);
    get_status(s);
    chk("R10 no char during held low", s[1], 0);
    wr_reg(2'd1, 8'h0B);

    send_rx(8'h11, 8'h4E, 1'b0, 0);
    send_rx(8'h22, 8'h4E, 1'b0, 0);
    get_status(s);
    chk("R11 overrun flagged", s[4], 1);
    rd_data(d);
    chk("R11 newer char kept", d, 8'h22);
    wr_reg(2'd1, 8'h0B);

    tick_wait(1);
    rxd = 1'b0; tick_wait(3);
    rxd = 1'b1; tick_wait(40);
    get_status(s);
    chk("R7 glitch ignored", s[1], 0);

    wr_reg(2'd2, 8'h4F);
    send_rx(8'h96, 8'h4F, 1'b0, 0);
    rd_data(d);
    chk("R6 x64 data", d, 8'h96);
    wr_reg(2'd2, 8'h4D);
    send_rx(8'h5A, 8'h4D, 1'b0, 0);
    rd_data(d);
    chk("R6 x1 data", d, 8'h5A);

    wr_reg(2'd2, 8'h4E);
    wr_reg(2'd1, 8'h01);
    send_rx(8'h77, 8'h4E, 1'b0, 0);
    get_status(s);
    chk("R13 rx disabled no ready", s[1], 0);
    rd_data(d);
    chk("R13 rx disabled buffer kept", d, 8'h5A);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule